// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This unit resolves read-after-write data hazards for a five-stage, in-order integer pipeline. It works in the decode stage. It takes the two source register numbers of the instruction being decoded and checks them against the destinations of the two older instructions still in flight. For each ALU operand it picks where the value will come from once the instruction reaches execute. The choices are the register file, the ALU result held one stage ahead, the ALU result held two stages ahead, or load data held two stages ahead. These choices are registered with the instruction as it moves into execute.

Some dependencies cannot be covered by a bypass. This happens when the instruction now in execute is a load and its destination is a source of the decoding instruction. In that case the unit raises a stall in the same cycle. The surrounding pipeline holds the program counter and the fetch/decode register, and the unit places a bubble into execute. Older instructions keep moving. A store whose data register is the only match against such a load does not stall. Instead it is marked so that the memory stage takes the load's data straight from the write-back register.

An instruction three ahead needs no handling, because the register file writes in the first half of a cycle and reads in the second. For that reason the write-back stage's destination is not an input.

Top module: `fwd_hazard_unit`

## Requirements
- R1: While reset is high, at the next clock edge `ex_sel_a`, `ex_sel_b` and `mem_store_fwd` become 0.
- R2: A source register number of 0 never produces a forward or a stall, even when an older destination is 0 with its write enable set.
- R3: An older destination whose write-enable input is low never produces a forward or a stall.
- R4: When a source matches the ID/EX destination of a non-load, the select registered for that operand after the next edge is 1 (the EX/MEM ALU result).
- R5: When a source matches only the EX/MEM destination, the registered select is 2 (MEM/WB ALU result) if that instruction is not a load, and 3 (MEM/WB load data) if it is. No stall is raised.
- R6: When both older instructions write the matching register, the ID/EX one (the younger) decides the select.
- R7: `stall` is high in the same cycle, combinationally, exactly when the ID/EX instruction is a load with its write enable set, a nonzero destination, and a destination equal to rs1, or equal to rs2 when the decoding instruction is not a store.
- R8: After a cycle with `stall` high, both registered selects are 0 and the store-forward mark entering execute is cleared (a bubble).
- R9: A decoding store whose rs2 matches an ID/EX load, while rs1 does not, raises no stall. Its registered `ex_sel_b` is 0, and `mem_store_fwd` is high after the second following clock edge.
- R10: The two operands are resolved independently. The select of one operand depends only on its own source number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | AW | First source register of the decoding instruction |
| id_rs2 | input | AW | Second source register of the decoding instruction |
| id_is_store | input | 1 | Decoding instruction is a store (rs2 is store data) |
| idex_rd | input | AW | Destination in the ID/EX register |
| idex_we | input | 1 | ID/EX instruction writes a register |
| idex_load | input | 1 | ID/EX instruction is a load |
| exmem_rd | input | AW | Destination in the EX/MEM register |
| exmem_we | input | 1 | EX/MEM instruction writes a register |
| exmem_load | input | 1 | EX/MEM instruction is a load |
| stall | output | 1 | Hold fetch and decode, bubble into execute |
| ex_sel_a | output | 2 | Operand A select for execute (0 regfile, 1 EX/MEM ALU, 2 MEM/WB ALU, 3 MEM/WB load) |
| ex_sel_b | output | 2 | Operand B select for execute, same encoding |
| mem_store_fwd | output | 1 | Memory stage takes store data from MEM/WB load data |

## Verification
The bench builds the unit with a 3-bit register number. This makes random sources and destinations collide on most cycles and hit register 0 about one time in eight. As a result, double matches, the zero register and write-disabled matches all come up in the random phase alongside the directed cases. Store data marks are followed through both registered stages, including stretches of back-to-back stalls.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_RF         = 2'd0,
        SEL_EXMEM_ALU  = 2'd1,
        SEL_MEMWB_ALU  = 2'd2,
        SEL_MEMWB_LOAD = 2'd3
    } fwd_sel_e;

    typedef struct packed {
        fwd_sel_e sel_a;
        fwd_sel_e sel_b;
        logic     store_fwd;
    } ex_ctrl_t;

    localparam int NUM_SRC = 2;

    // Younger producer wins; a load one ahead cannot be bypassed here.
    function automatic fwd_sel_e pick_source(
        input logic hit_young, input logic young_is_load,
        input logic hit_old,   input logic old_is_load);
        if (hit_young)
            return young_is_load ? SEL_RF : SEL_EXMEM_ALU;
        else if (hit_old)
            return old_is_load ? SEL_MEMWB_LOAD : SEL_MEMWB_ALU;
        else
            return SEL_RF;
    endfunction

endpackage

// File: rtl/fwd_src_cmp.sv
`timescale 1ns/1ps
module fwd_src_cmp
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          rst,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] idex_rd,
    input  logic          idex_we,
    input  logic          idex_load,
    input  logic [AW-1:0] exmem_rd,
    input  logic          exmem_we,
    input  logic          exmem_load,
    output fwd_sel_e      sel,
    output logic          load_hit
);
    logic src_live;
    logic hit_young;
    logic hit_old;

    always_comb begin
        src_live  = (src != '0);
        hit_young = src_live && idex_we  && (idex_rd  == src);
        hit_old   = src_live && exmem_we && (exmem_rd == src);
        load_hit  = hit_young && idex_load;
        sel       = pick_source(hit_young, idex_load, hit_old, exmem_load);
    end

    // R2: register 0 is never a forwarding source
    always_comb begin
        if (!rst) begin
            a_r2_zero_never_fwd: assert (!(src == '0 && (sel != SEL_RF || load_hit)));
        end
    end

endmodule

// File: rtl/fwd_ctrl_pipe.sv
`timescale 1ns/1ps
module fwd_ctrl_pipe
    import fwd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bubble,
    input  ex_ctrl_t id_ctrl,
    output ex_ctrl_t ex_ctrl,
    output logic     mem_store_fwd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ex_ctrl       <= '0;
            mem_store_fwd <= 1'b0;
        end else begin
            ex_ctrl       <= bubble ? '0 : id_ctrl;
            mem_store_fwd <= ex_ctrl.store_fwd;
        end
    end

    // R8: a stalled decode leaves a bubble in execute
    a_r8_bubble_clears: assert property (@(posedge clk) disable iff (rst)
        bubble |=> (ex_ctrl.sel_a == SEL_RF && ex_ctrl.sel_b == SEL_RF && !ex_ctrl.store_fwd));

    // R1: reset empties both stages
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (ex_ctrl == '0 && !mem_store_fwd));

endmodule

// File: rtl/fwd_hazard_unit.sv
`timescale 1ns/1ps
module fwd_hazard_unit
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_is_store,
    input  logic [AW-1:0] idex_rd,
    input  logic          idex_we,
    input  logic          idex_load,
    input  logic [AW-1:0] exmem_rd,
    input  logic          exmem_we,
    input  logic          exmem_load,
    output logic          stall,
    output logic [1:0]    ex_sel_a,
    output logic [1:0]    ex_sel_b,
    output logic          mem_store_fwd
);
    localparam int DATA_SRC = NUM_SRC - 1;

    logic [AW-1:0] srcs     [NUM_SRC];
    fwd_sel_e      sels     [NUM_SRC];
    logic          load_hit [NUM_SRC];
    ex_ctrl_t      id_ctrl;
    ex_ctrl_t      ex_ctrl;
    logic          store_escape;

    assign srcs[0] = id_rs1;
    assign srcs[1] = id_rs2;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        fwd_src_cmp #(.AW(AW)) u_cmp (
            .rst        (rst),
            .src        (srcs[i]),
            .idex_rd    (idex_rd),
            .idex_we    (idex_we),
            .idex_load  (idex_load),
            .exmem_rd   (exmem_rd),
            .exmem_we   (exmem_we),
            .exmem_load (exmem_load),
            .sel        (sels[i]),
            .load_hit   (load_hit[i])
        );
    end

    always_comb begin
        store_escape      = id_is_store && load_hit[DATA_SRC];
        stall             = load_hit[0] || (load_hit[DATA_SRC] && !id_is_store);
        id_ctrl.sel_a     = sels[0];
        id_ctrl.sel_b     = sels[DATA_SRC];
        id_ctrl.store_fwd = store_escape;
    end

    fwd_ctrl_pipe u_pipe (
        .clk           (clk),
        .rst           (rst),
        .bubble        (stall),
        .id_ctrl       (id_ctrl),
        .ex_ctrl       (ex_ctrl),
        .mem_store_fwd (mem_store_fwd)
    );

    assign ex_sel_a = ex_ctrl.sel_a;
    assign ex_sel_b = ex_ctrl.sel_b;

    // R7: a stall is only ever caused by a live load one stage ahead
    a_r7_stall_needs_load: assert property (@(posedge clk) disable iff (rst)
        stall |-> (idex_load && idex_we && idex_rd != '0));

    // R9: a store whose only dependency is its data on a load keeps moving
    a_r9_store_no_stall: assert property (@(posedge clk) disable iff (rst)
        (id_is_store && idex_load && idex_we && idex_rd != '0 &&
         id_rs2 == idex_rd && id_rs1 != idex_rd) |-> !stall);

endmodule

// File: tb/fwd_hazard_unit_bench.sv
`timescale 1ns/1ps
module fwd_hazard_unit_bench;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, idex_rd = '0, exmem_rd = '0;
    logic          id_is_store = 1'b0, idex_we = 1'b0, idex_load = 1'b0;
    logic          exmem_we = 1'b0, exmem_load = 1'b0;
    logic          stall;
    logic [1:0]    ex_sel_a, ex_sel_b;
    logic          mem_store_fwd;

    int n_cmp = 0;
    int n_bad = 0;

    // model state
    logic [1:0] m_a = 0, m_b = 0;
    logic       m_sf_ex = 0, m_sf_mem = 0;

    always #2.5 clk = ~clk;

    fwd_hazard_unit #(.AW(AW)) u_fwd_hazard_unit (
        .clk(clk), .rst(rst), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_is_store(id_is_store), .idex_rd(idex_rd), .idex_we(idex_we),
        .idex_load(idex_load), .exmem_rd(exmem_rd), .exmem_we(exmem_we),
        .exmem_load(exmem_load), .stall(stall), .ex_sel_a(ex_sel_a),
        .ex_sel_b(ex_sel_b), .mem_store_fwd(mem_store_fwd)
    );

    function automatic logic young_hit(input logic [AW-1:0] s);
        return (s != 0) && idex_we && (idex_rd == s);
    endfunction

    function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
        if (young_hit(s)) return idex_load ? 2'd0 : 2'd1;
        if ((s != 0) && exmem_we && (exmem_rd == s)) return exmem_load ? 2'd3 : 2'd2;
        return 2'd0;
    endfunction

    function automatic logic exp_stall();
        return idex_load && (young_hit(id_rs1) || (young_hit(id_rs2) && !id_is_store));
    endfunction

    task automatic check(input string req, input string what, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic drive(input logic [AW-1:0] r1, input logic [AW-1:0] r2, input logic st,
                         input logic [AW-1:0] yd, input logic yw, input logic yl,
                         input logic [AW-1:0] od, input logic ow, input logic ol);
        id_rs1 = r1; id_rs2 = r2; id_is_store = st;
        idex_rd = yd; idex_we = yw; idex_load = yl;
        exmem_rd = od; exmem_we = ow; exmem_load = ol;
    endtask

    // one decode cycle: inputs at negedge, stall checked before the edge,
    // registered outputs checked just after it
    task automatic step(input string req);
        logic       s;
        logic [1:0] na, nb;
        logic       nsf;
        #1;
        s   = exp_stall();
        na  = exp_sel(id_rs1);
        nb  = (id_is_store && idex_load && young_hit(id_rs2)) ? 2'd0 : exp_sel(id_rs2);
        nsf = id_is_store && idex_load && young_hit(id_rs2);
        check(req, "stall", stall, s);
        @(posedge clk);
        m_sf_mem = m_sf_ex;
        m_sf_ex  = s ? 1'b0 : nsf;
        m_a      = s ? 2'd0 : na;
        m_b      = s ? 2'd0 : nb;
        #1;
        check(req, "ex_sel_a", ex_sel_a, m_a);
        check(req, "ex_sel_b", ex_sel_b, m_b);
        check(req, "mem_store_fwd", mem_store_fwd, m_sf_mem);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        // R1: reset with a forwarding pattern present
        drive(3'd2, 3'd3, 1'b0, 3'd2, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        check("R1", "ex_sel_a", ex_sel_a, 0);
        check("R1", "ex_sel_b", ex_sel_b, 0);
        check("R1", "mem_store_fwd", mem_store_fwd, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2: register 0 on both sides
        drive(3'd0, 3'd0, 1'b0, 3'd0, 1'b1, 1'b1, 3'd0, 1'b1, 1'b0); step("R2");
        // R3: write enables low
        drive(3'd4, 3'd5, 1'b0, 3'd4, 1'b0, 1'b1, 3'd5, 1'b0, 1'b0); step("R3");
        // R4: ALU result one ahead
        drive(3'd4, 3'd1, 1'b0, 3'd4, 1'b1, 1'b0, 3'd7, 1'b1, 1'b0); step("R4");
        // R5: two ahead, ALU then load
        drive(3'd1, 3'd6, 1'b0, 3'd2, 1'b1, 1'b0, 3'd6, 1'b1, 1'b0); step("R5");
        drive(3'd6, 3'd1, 1'b0, 3'd2, 1'b1, 1'b0, 3'd6, 1'b1, 1'b1); step("R5");
        // R6: both ahead write the same register
        drive(3'd3, 3'd3, 1'b0, 3'd3, 1'b1, 1'b0, 3'd3, 1'b1, 1'b1); step("R6");
        // R10: one operand bypassed, the other untouched
        drive(3'd5, 3'd2, 1'b0, 3'd2, 1'b1, 1'b0, 3'd1, 1'b1, 1'b0); step("R10");
        // R7 and R8: load-use stall, then the load moves on
        drive(3'd5, 3'd2, 1'b0, 3'd5, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0); step("R7 R8");
        drive(3'd5, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0, 3'd5, 1'b1, 1'b1); step("R8");
        // R7: load matching rs2 of a non-store
        drive(3'd1, 3'd6, 1'b0, 3'd6, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0); step("R7");
        // R9: store data on a load one ahead, then follow it into memory
        drive(3'd1, 3'd6, 1'b1, 3'd6, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0); step("R9");
        drive(3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0); step("R9");
        // R9 with the address also on the load: it stalls
        drive(3'd6, 3'd6, 1'b1, 3'd6, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0); step("R7 R9");

        for (int i = 0; i < 3000; i++) begin
            drive($urandom, $urandom, ($urandom % 3) == 0, $urandom, $urandom, $urandom,
                  $urandom, $urandom, $urandom);
            step("R4 R5 R6 R7 R9 R10");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule